// File: doc/BRIEF.md
# Paired Output Compare Channel Unit

This block holds two compare channels that watch an external free-running timer count. Each channel keeps a 16-bit compare value. While the channel is started, the block checks that value against the timer count on every clock. When the two are equal, the channel raises its interrupt flag. If the channel's output pin is enabled, the match also inverts that pin's current level.

Both channels share one 16-bit control word. It holds per-channel start, interrupt enable, interrupt flag, pin enable and pin level bits. It also holds one routing mode bit. In mode 0 each pin follows only its own channel. In mode 1, pin 1 toggles on a match of either channel, so the pair can make a waveform with set and reset edges from two compare values.

Software reaches the three registers through a word-wide bus with byte enables. Reads are combinational. Three instances of the unit give six channels.

Top module: `occ_pair`

## Requirements
- R1: The compare registers are at select 0 (channel 0) and select 1 (channel 1). Each is 16 bits and clears to 0 on reset. A write is taken only when both byte enables are set; any write with a partial byte enable leaves the register unchanged.
- R2: While a channel's start bit is 1 and its compare value equals `timer_cnt` at a clock edge, that channel's flag reads as 1 from the next cycle on.
- R3: While a channel's start bit is 0, it produces no matches, so its flag and the pins are unaffected.
- R4: A flag stays set until software writes 0 to it in a low-byte write of the control word. Writing 1 to a flag leaves it unchanged. A match in the same cycle as a clearing write wins.
- R5: `irq` is high exactly when some channel has both its flag and its interrupt enable at 1.
- R6: A match inverts an enabled pin in the following cycle. A disabled pin drives 0 and does not toggle.
- R7: In mode 0, pin 0 toggles on channel 0 matches and pin 1 toggles on channel 1 matches. In mode 1, pin 0 toggles on channel 0 matches and pin 1 toggles on a match of either channel.
- R8: The pin level bits (bit 8 for pin 0, bit 9 for pin 1) read back the current levels. A high-byte write sets a pin's level to the written level bit if that write also sets the pin's enable bit.
- R9: Holding the timer at a matching count for several clocks gives one match, not one per clock.
- R10: The control word is at select 2. Its bits are:
  - bits 1:0: start, channel 1 at bit 1 and channel 0 at bit 0
  - bits 5:4: interrupt enables
  - bits 7:6: flags
  - bits 9:8: pin levels
  - bits 11:10: pin enables
  - bit 12: mode
  
  Bits 15:13 and 3:2 read 0. All bits reset to 0, and select 3 reads 0.
- R11: A control write with only byte enable 0 changes only bits 7:0. A control write with only byte enable 1 changes only bits 15:8, apart from matches that occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 and 1 compare, 2 control |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| timer_cnt | input | 16 | Free-running timer count |
| pin_out | output | 2 | Compare output pins |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong compare value or a match detector that is stuck shows at the ports one cycle after the timer reaches the count. It appears as a missing or extra flag in the control word read-back, an `irq` change, or a pin that fails to invert. A detector that re-fires while the timer holds shows as a pin that flips back on the next cycle. A wrong routing in mode 1 shows on pin 1 right after a channel 0 match. Errors in byte-lane decode or in flag write-to-clear are caught by the first read-back of the control word after the write.

// File: rtl/occ_pkg.sv
package occ_pkg;
  // bit positions inside the shared control word (software visible)
  localparam int CW_W      = 16;
  localparam int CW_START  = 0;   // two bits
  localparam int CW_IE     = 4;   // two bits
  localparam int CW_FLAG   = 6;   // two bits
  localparam int CW_LVL    = 8;   // two bits
  localparam int CW_PEN    = 10;  // two bits
  localparam int CW_MODE   = 12;  // one bit
  localparam int NCH       = 2;

  typedef enum logic [1:0] {
    SEL_CMP0 = 2'd0,
    SEL_CMP1 = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } occ_sel_e;

  typedef struct packed {
    logic             mode;
    logic [NCH-1:0]   pen;
    logic [NCH-1:0]   lvl;
    logic [NCH-1:0]   flag;
    logic [NCH-1:0]   ie;
    logic [NCH-1:0]   start;
  } occ_ctrl_t;
endpackage

// File: rtl/occ_cmp_chan.sv
module occ_cmp_chan #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_full,
  input  logic [TW-1:0] wdata,
  input  logic          start,
  input  logic [TW-1:0] timer,
  output logic [TW-1:0] cmp_val,
  output logic          match_pulse
);
  logic [TW-1:0] cmp_q, cmp_d;
  logic [TW-1:0] tim_q;
  logic          hit, hit_q;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_full) cmp_d = wdata;
  end

  assign hit = start && (cmp_q == timer);
  // a match is reported once per timer value: suppress when last cycle
  // already hit on the same count
  assign match_pulse = hit && !(hit_q && (tim_q == timer));
  assign cmp_val     = cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      tim_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (wr_full) cmp_q <= cmp_d;
      tim_q <= timer;
      hit_q <= hit;
    end
  end
endmodule

// File: rtl/occ_ctrl.sv
module occ_ctrl
  import occ_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [CW_W-1:0]  wdata,
  input  logic [NCH-1:0]   pulse,
  output logic [NCH-1:0]   start,
  output logic [CW_W-1:0]  ctrl_word,
  output logic [NCH-1:0]   pin_out,
  output logic             irq
);
  occ_ctrl_t cur_q, nxt;
  logic [NCH-1:0] tgl;

  // pin routing: pin 0 always follows channel 0; pin 1 follows channel 1
  // alone in mode 0, either channel in mode 1
  assign tgl[0] = pulse[0];
  assign tgl[1] = cur_q.mode ? (pulse[0] | pulse[1]) : pulse[1];

  always_comb begin
    nxt = cur_q;
    if (wr_lo) begin
      nxt.start = wdata[CW_START +: NCH];
      nxt.ie    = wdata[CW_IE    +: NCH];
      nxt.flag  = cur_q.flag & wdata[CW_FLAG +: NCH];
    end
    nxt.flag = nxt.flag | pulse;
    for (int i = 0; i < NCH; i++) begin
      if (cur_q.pen[i] && tgl[i]) nxt.lvl[i] = ~cur_q.lvl[i];
    end
    if (wr_hi) begin
      nxt.mode = wdata[CW_MODE];
      nxt.pen  = wdata[CW_PEN +: NCH];
      for (int i = 0; i < NCH; i++) begin
        if (wdata[CW_PEN + i]) nxt.lvl[i] = wdata[CW_LVL + i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  always_comb begin
    ctrl_word                      = '0;
    ctrl_word[CW_START +: NCH]     = cur_q.start;
    ctrl_word[CW_IE    +: NCH]     = cur_q.ie;
    ctrl_word[CW_FLAG  +: NCH]     = cur_q.flag;
    ctrl_word[CW_LVL   +: NCH]     = cur_q.lvl;
    ctrl_word[CW_PEN   +: NCH]     = cur_q.pen;
    ctrl_word[CW_MODE]             = cur_q.mode;
  end

  assign start   = cur_q.start;
  assign pin_out = cur_q.pen & cur_q.lvl;
  assign irq     = |(cur_q.flag & cur_q.ie);
endmodule

// File: rtl/occ_pair.sv
module occ_pair
  import occ_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_be,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  input  logic [TW-1:0] timer_cnt,
  output logic [1:0]    pin_out,
  output logic          irq
);
  localparam int DW = 16;

  logic [NCH-1:0]  pulse_w;
  logic [NCH-1:0]  start_w;
  logic [TW-1:0]   cmp_w [NCH];
  logic [DW-1:0]   ctrl_w;
  logic            ctl_hit, wr_lo, wr_hi;
  logic [NCH-1:0]  cmp_wr;

  assign ctl_hit = bus_we && (bus_sel == SEL_CTRL);
  assign wr_lo   = ctl_hit && bus_be[0];
  assign wr_hi   = ctl_hit && bus_be[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // compare registers only take whole-word writes
    assign cmp_wr[c] = bus_we && (bus_sel == 2'(c)) && (bus_be == 2'b11);
    occ_cmp_chan #(.TW(TW)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_full     (cmp_wr[c]),
      .wdata       (bus_wdata[TW-1:0]),
      .start       (start_w[c]),
      .timer       (timer_cnt),
      .cmp_val     (cmp_w[c]),
      .match_pulse (pulse_w[c])
    );
  end

  occ_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wdata     (bus_wdata),
    .pulse     (pulse_w),
    .start     (start_w),
    .ctrl_word (ctrl_w),
    .pin_out   (pin_out),
    .irq       (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_sel)
      SEL_CMP0: bus_rdata = DW'(cmp_w[0]);
      SEL_CMP1: bus_rdata = DW'(cmp_w[1]);
      SEL_CTRL: bus_rdata = ctrl_w;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/occ_pair_chk.sv
module occ_pair_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_sel,
  input logic          bus_we,
  input logic [1:0]    bus_be,
  input logic [15:0]   bus_rdata,
  input logic [TW-1:0] timer_cnt,
  input logic [1:0]    pin_out,
  input logic          irq,
  input logic [1:0]    pulse,
  input logic [1:0]    start,
  input logic [15:0]   ctrl_word,
  input logic [TW-1:0] cmp0
);
  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse[0] |=> ctrl_word[6]);
  // R3
  idle_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start[1] |-> !pulse[1]);
  // R9
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse[0] |=> !(pulse[0] && $stable(timer_cnt)));
  // R6
  pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[10] |-> !pin_out[0]);
  // R6
  pin_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[10] && pulse[0] && !(bus_we && bus_sel == 2'd2 && bus_be[1]))
      |=> pin_out[0] != $past(pin_out[0]));
  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 2'd2) |-> (bus_rdata[15:13] == 3'b000 && bus_rdata[3:2] == 2'b00));
  // R1
  partial_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 2'd0 && bus_be != 2'b11) |=> $stable(cmp0));
  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[7:6] == 2'b00) |-> !irq);
endmodule

bind occ_pair occ_pair_chk #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_be    (bus_be),
  .bus_rdata (bus_rdata),
  .timer_cnt (timer_cnt),
  .pin_out   (pin_out),
  .irq       (irq),
  .pulse     (pulse_w),
  .start     (start_w),
  .ctrl_word (ctrl_w),
  .cmp0      (cmp_w[0])
);

// File: tb/sim_occ_pair.sv
module sim_occ_pair;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;
  localparam logic [15:0] IDLE_T = 16'hF000;

  // vector: kind(2) sel(2) be(2) wdata(16) timer(16) expect(16) req(4)
  // kind 0 write, 1 read and compare rdata, 2 clock once then compare {irq,pin_out}
  localparam logic [57:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 2'b11, 16'h0100, IDLE_T,   16'h0000, 4'd1},  // R1 cmp0
    {2'd0, 2'd1, 2'b11, 16'h0200, IDLE_T,   16'h0000, 4'd1},  // R1 cmp1
    {2'd1, 2'd0, 2'b00, 16'h0000, IDLE_T,   16'h0100, 4'd1},  // R1
    {2'd0, 2'd0, 2'b01, 16'hAAAA, IDLE_T,   16'h0000, 4'd1},  // R1 partial
    {2'd1, 2'd0, 2'b00, 16'h0000, IDLE_T,   16'h0100, 4'd1},  // R1 unchanged
    {2'd0, 2'd2, 2'b11, 16'h0C33, IDLE_T,   16'h0000, 4'd10}, // R10
    {2'd1, 2'd2, 2'b00, 16'h0000, IDLE_T,   16'h0C33, 4'd10}, // R10
    {2'd2, 2'd0, 2'b00, 16'h0000, 16'h0100, 16'h0005, 4'd6},  // R6 R2
    {2'd1, 2'd2, 2'b00, 16'h0000, 16'h0100, 16'h0D73, 4'd2},  // R2 R8
    {2'd2, 2'd0, 2'b00, 16'h0000, 16'h0100, 16'h0005, 4'd9},  // R9 held
    {2'd2, 2'd0, 2'b00, 16'h0000, 16'h0200, 16'h0007, 4'd7},  // R7 mode 0
    {2'd0, 2'd2, 2'b01, 16'h00B3, IDLE_T,   16'h0000, 4'd4},  // R4
    {2'd1, 2'd2, 2'b00, 16'h0000, IDLE_T,   16'h0FB3, 4'd4},  // R4 R11
    {2'd0, 2'd2, 2'b01, 16'h0003, IDLE_T,   16'h0000, 4'd4},  // R4
    {2'd2, 2'd0, 2'b00, 16'h0000, IDLE_T,   16'h0003, 4'd5},  // R5
    {2'd0, 2'd2, 2'b10, 16'h1C00, IDLE_T,   16'h0000, 4'd8},  // R8 preset 0
    {2'd1, 2'd2, 2'b00, 16'h0000, IDLE_T,   16'h1C03, 4'd11}, // R11
    {2'd2, 2'd0, 2'b00, 16'h0000, 16'h0100, 16'h0003, 4'd7},  // R7 mode 1
    {2'd2, 2'd0, 2'b00, 16'h0000, 16'h0200, 16'h0001, 4'd7},  // R7
    {2'd0, 2'd2, 2'b01, 16'h00C0, IDLE_T,   16'h0000, 4'd3},  // R3 stop
    {2'd2, 2'd0, 2'b00, 16'h0000, 16'h0100, 16'h0001, 4'd3},  // R3
    {2'd1, 2'd2, 2'b00, 16'h0000, 16'h0100, 16'h1DC0, 4'd3}   // R3
  };

  logic        clk, rst_n, bus_we, irq;
  logic [1:0]  bus_sel, bus_be, pin_out;
  logic [15:0] bus_wdata, bus_rdata, timer_cnt;
  int n_chk, n_fail;
  bit done;

  occ_pair u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_cnt(timer_cnt), .pin_out(pin_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] be, input logic [15:0] d);
    bus_sel = sel; bus_be = be; bus_wdata = d; timer_cnt = IDLE_T; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int req, input logic [1:0] sel, input logic [15:0] exp);
    bus_sel = sel; #1;
    chk(req, bus_rdata, exp, "read");
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tk(input int req, input logic [15:0] t, input logic [2:0] exp);
    timer_cnt = t;
    @(posedge clk); @(negedge clk);
    chk(req, {13'b0, irq, pin_out}, {13'b0, exp}, "irq/pins");
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_we = 1'b0; bus_sel = 2'd0; bus_be = 2'b00;
    bus_wdata = '0; timer_cnt = IDLE_T;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    do_reset();
    // R10 R1 reset state
    rd(1, 2'd0, 16'h0000);
    rd(1, 2'd1, 16'h0000);
    rd(10, 2'd2, 16'h0000);
    chk(6, {14'b0, pin_out}, 16'h0000, "reset pins");

    for (int i = 0; i < NVEC; i++) begin
      logic [57:0] v;
      v = VEC[i];
      bus_sel = v[55:54]; bus_be = v[53:52]; bus_wdata = v[51:36];
      timer_cnt = v[35:20];
      case (v[57:56])
        2'd0: begin
          bus_we = 1'b1;
          @(posedge clk); @(negedge clk);
          bus_we = 1'b0;
        end
        2'd1: begin
          #1 chk(int'(v[3:0]), bus_rdata, v[19:4], "vector read");
          @(posedge clk); @(negedge clk);
        end
        default: begin
          @(posedge clk); @(negedge clk);
          chk(int'(v[3:0]), {13'b0, irq, pin_out}, v[19:4], "vector irq/pins");
        end
      endcase
    end

    // directed corner cases after a fresh reset
    do_reset();
    rd(10, 2'd2, 16'h0000);                 // R10 reset clears control
    wr(2'd0, 2'b11, 16'h0005);
    wr(2'd2, 2'b11, 16'h0001);              // start 0 only, pins off
    tk(6, 16'h0005, 3'b000);                // R6 disabled pin stays low, R5 ie off
    rd(2, 2'd2, 16'h0041);                  // R2 flag 0 set
    wr(2'd2, 2'b01, 16'h0051);              // enable interrupt 0
    tk(5, IDLE_T, 3'b100);                  // R5 irq high
    wr(2'd2, 2'b01, 16'h00C1);              // R4 writing 1 to flags, ie off
    rd(4, 2'd2, 16'h0041);                  // R4 flag 1 not set, flag 0 kept
    tk(5, IDLE_T, 3'b000);                  // R5 irq low with ie off
    wr(2'd2, 2'b10, 16'h0A00);              // R8 preset pin 1 high
    tk(8, IDLE_T, 3'b010);                  // R8
    rd(11, 2'd2, 16'h0A41);                 // R11 low byte untouched
    rd(10, 2'd3, 16'h0000);                 // R10 empty select

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule